// File: doc/BRIEF.md
# Highway and Farm-Road Crossing Signal Controller

This block sequences the signal lamps at a crossing where a busy highway meets a lightly used farm road. The highway is favoured: it keeps a green lamp until a vehicle is sensed on the farm road and the highway has already shown green for at least a long interval. The farm road then gets a green lamp for as long as vehicles keep arriving, but never longer than that same long interval. Each green-to-red change goes through a yellow phase whose length is a short interval.

The controller holds four phases. In order they are: highway go, highway warn, farm go and farm warn. It also contains its own interval counter, so it needs only a clock, a reset and the farm-road vehicle sense line. The counter restarts on every phase change and reports when the short and long intervals have run out. Each road's lamps come out registered as a three-bit one-hot code. A restart strobe marks the first cycle of each new phase.

Top module: `crossing_signal_ctrl`

## Requirements
- R1: A synchronous active-high reset puts the block in highway go. The highway lamp is green, the farm lamp is red, `timer_start` is low and the interval counter restarts. This holds from the cycle after the reset edge.
- R2: Each lamp output is one-hot with green = 3'b001 (bit 0), yellow = 3'b010 (bit 1) and red = 3'b100 (bit 2). Exactly one lamp per road is lit in every cycle.
- R3: Highway go is left only at an edge where `car_waiting` is high and highway go has lasted at least LONG_CYCLES cycles. When the car is present from the start, the phase lasts exactly LONG_CYCLES cycles.
- R4: While `car_waiting` is low, highway go is held for any length of time.
- R5: Highway warn (highway yellow, farm red) lasts exactly SHORT_CYCLES cycles, then farm go follows.
- R6: Farm go (highway red, farm green) ends at the first edge where `car_waiting` is low, or after LONG_CYCLES cycles, whichever comes first. It therefore never exceeds LONG_CYCLES cycles.
- R7: Farm warn (highway red, farm yellow) lasts exactly SHORT_CYCLES cycles, then highway go follows.
- R8: `timer_start` is high exactly in the first cycle of each new phase and low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| car_waiting | input | 1 | Vehicle sensed on the farm road |
| hwy_lamp | output | 3 | Highway lamp, one-hot {red, yellow, green} |
| farm_lamp | output | 3 | Farm-road lamp, one-hot {red, yellow, green} |
| timer_start | output | 1 | Interval restart strobe, high in the first cycle of each phase |

## Verification
Farm go is the hardest phase to drive into its two different endings. One ending is a farm go cut to a single cycle, where the sense line is already low when the phase begins. In that case restart strobes occur in two consecutive cycles. The other ending is a farm go that reaches the long cap while vehicles keep arriving. Directed segments hold the sense line high across whole cycles and toggle it every cycle. They also drop it after long quiet stretches and apply a reset in mid-phase. Random segments with rare toggles then cover the phase boundaries at many offsets. A bench reference model and run-length checks on both green lamps confirm the minimum highway green and the maximum farm green.

// File: rtl/crossing_pkg.sv
package crossing_pkg;

  typedef enum logic [1:0] {
    PH_HWY_GO    = 2'd0,
    PH_HWY_WARN  = 2'd1,
    PH_FARM_GO   = 2'd2,
    PH_FARM_WARN = 2'd3
  } phase_t;

  localparam logic [2:0] LAMP_GREEN  = 3'b001;
  localparam logic [2:0] LAMP_YELLOW = 3'b010;
  localparam logic [2:0] LAMP_RED    = 3'b100;

endpackage

// File: rtl/crossing_interval_timer.sv
module crossing_interval_timer #(
  parameter int SHORT_CYCLES = 4,
  parameter int LONG_CYCLES  = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic short_done,
  output logic long_done
);
  localparam int CNT_W = $clog2(LONG_CYCLES + 1);
  localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(SHORT_CYCLES - 1);
  localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(LONG_CYCLES - 1);

  // count = number of cycles already spent in the current phase
  logic [CNT_W-1:0] count_q;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      count_q <= '0;
    end else if (count_q != LONG_LAST) begin
      count_q <= count_q + 1'b1;
    end
  end

  assign short_done = (count_q >= SHORT_LAST);
  assign long_done  = (count_q == LONG_LAST);

endmodule

// File: rtl/crossing_phase_fsm.sv
module crossing_phase_fsm
  import crossing_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   car_waiting,
  input  logic   short_done,
  input  logic   long_done,
  output phase_t phase_nxt,
  output logic   advance
);
  phase_t phase_q;

  always_comb begin
    phase_nxt = phase_q;
    advance   = 1'b0;
    unique case (phase_q)
      PH_HWY_GO: begin
        if (car_waiting && long_done) begin
          phase_nxt = PH_HWY_WARN;
          advance   = 1'b1;
        end
      end
      PH_HWY_WARN: begin
        if (short_done) begin
          phase_nxt = PH_FARM_GO;
          advance   = 1'b1;
        end
      end
      PH_FARM_GO: begin
        if (!car_waiting || long_done) begin
          phase_nxt = PH_FARM_WARN;
          advance   = 1'b1;
        end
      end
      PH_FARM_WARN: begin
        if (short_done) begin
          phase_nxt = PH_HWY_GO;
          advance   = 1'b1;
        end
      end
      default: begin
        phase_nxt = PH_HWY_GO;
        advance   = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) phase_q <= PH_HWY_GO;
    else     phase_q <= phase_nxt;
  end

endmodule

// File: rtl/crossing_lamp_decode.sv
module crossing_lamp_decode
  import crossing_pkg::*;
(
  input  phase_t     phase,
  output logic [2:0] hwy,
  output logic [2:0] farm
);
  always_comb begin
    unique case (phase)
      PH_HWY_GO:    begin hwy = LAMP_GREEN;  farm = LAMP_RED;    end
      PH_HWY_WARN:  begin hwy = LAMP_YELLOW; farm = LAMP_RED;    end
      PH_FARM_GO:   begin hwy = LAMP_RED;    farm = LAMP_GREEN;  end
      PH_FARM_WARN: begin hwy = LAMP_RED;    farm = LAMP_YELLOW; end
      default:      begin hwy = LAMP_RED;    farm = LAMP_RED;    end
    endcase
  end
endmodule

// File: rtl/crossing_signal_ctrl.sv
module crossing_signal_ctrl
  import crossing_pkg::*;
#(
  parameter int SHORT_CYCLES = 4,
  parameter int LONG_CYCLES  = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       car_waiting,
  output logic [2:0] hwy_lamp,
  output logic [2:0] farm_lamp,
  output logic       timer_start
);
  logic       short_done;
  logic       long_done;
  logic       advance;
  phase_t     phase_nxt;
  logic [2:0] hwy_nxt;
  logic [2:0] farm_nxt;

  crossing_interval_timer #(
    .SHORT_CYCLES(SHORT_CYCLES),
    .LONG_CYCLES (LONG_CYCLES)
  ) timer_i (
    .clk       (clk),
    .rst       (rst),
    .restart   (advance),
    .short_done(short_done),
    .long_done (long_done)
  );

  crossing_phase_fsm fsm_i (
    .clk        (clk),
    .rst        (rst),
    .car_waiting(car_waiting),
    .short_done (short_done),
    .long_done  (long_done),
    .phase_nxt  (phase_nxt),
    .advance    (advance)
  );

  crossing_lamp_decode dec_i (
    .phase(phase_nxt),
    .hwy  (hwy_nxt),
    .farm (farm_nxt)
  );

  // lamps decoded from the next phase so the registered outputs line up with the state
  always_ff @(posedge clk) begin
    if (rst) begin
      hwy_lamp    <= LAMP_GREEN;
      farm_lamp   <= LAMP_RED;
      timer_start <= 1'b0;
    end else begin
      hwy_lamp    <= hwy_nxt;
      farm_lamp   <= farm_nxt;
      timer_start <= advance;
    end
  end

endmodule

// File: rtl/crossing_signal_chk.sv
module crossing_signal_chk
  import crossing_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       car_waiting,
  input logic [2:0] hwy_lamp,
  input logic [2:0] farm_lamp,
  input logic       timer_start
);
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (hwy_lamp == LAMP_GREEN && farm_lamp == LAMP_RED && !timer_start));

  a_r2_hwy_onehot: assert property (@(posedge clk) disable iff (rst)
    $countones(hwy_lamp) == 1);

  a_r2_farm_onehot: assert property (@(posedge clk) disable iff (rst)
    $countones(farm_lamp) == 1);

  a_r4_hwy_holds_without_car: assert property (@(posedge clk) disable iff (rst)
    (hwy_lamp == LAMP_GREEN && !car_waiting) |=> hwy_lamp == LAMP_GREEN);

  a_r6_farm_go_ends_on_empty: assert property (@(posedge clk) disable iff (rst)
    (farm_lamp == LAMP_GREEN && !car_waiting) |=> farm_lamp == LAMP_YELLOW);

  a_r5_hwy_green_to_yellow: assert property (@(posedge clk) disable iff (rst)
    hwy_lamp == LAMP_GREEN |=> (hwy_lamp == LAMP_GREEN || hwy_lamp == LAMP_YELLOW));

  a_r8_start_marks_change: assert property (@(posedge clk) disable iff (rst)
    timer_start |-> !$stable({hwy_lamp, farm_lamp}));

  a_r8_change_has_start: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$stable({hwy_lamp, farm_lamp})) |-> timer_start);
endmodule

bind crossing_signal_ctrl crossing_signal_chk chk_i (
  .clk        (clk),
  .rst        (rst),
  .car_waiting(car_waiting),
  .hwy_lamp   (hwy_lamp),
  .farm_lamp  (farm_lamp),
  .timer_start(timer_start)
);

// File: tb/crossing_signal_ctrl_tb_top.sv
`timescale 1ns/1ps
module crossing_signal_ctrl_tb_top;
  localparam int SHORT = 3;
  localparam int LONG  = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       car_waiting = 1'b0;
  logic [2:0] hwy_lamp;
  logic [2:0] farm_lamp;
  logic       timer_start;

  int n_cmp = 0;
  int n_bad = 0;

  // reference model: 0 hwy go, 1 hwy warn, 2 farm go, 3 farm warn
  int m_phase = 0;
  int m_cnt   = 0;
  bit m_st    = 0;
  int hg_run  = 0;
  int fg_run  = 0;

  always #4 clk = ~clk;

  crossing_signal_ctrl #(.SHORT_CYCLES(SHORT), .LONG_CYCLES(LONG)) dut_i (
    .clk(clk), .rst(rst), .car_waiting(car_waiting),
    .hwy_lamp(hwy_lamp), .farm_lamp(farm_lamp), .timer_start(timer_start)
  );

  function automatic logic [2:0] exp_hwy(int p);
    case (p)
      0: return 3'b001;
      1: return 3'b010;
      default: return 3'b100;
    endcase
  endfunction

  function automatic logic [2:0] exp_farm(int p);
    case (p)
      2: return 3'b001;
      3: return 3'b010;
      default: return 3'b100;
    endcase
  endfunction

  function automatic string phase_req(int p, bit in_rst);
    if (in_rst) return "R1";
    case (p)
      0: return "R3/R4";
      1: return "R5";
      2: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check(string req, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step(input logic c, input logic r);
    bit was_rst;
    bit ex;
    @(negedge clk);
    was_rst = rst;
    check(phase_req(m_phase, was_rst), "hwy_lamp", hwy_lamp, exp_hwy(m_phase));
    check(phase_req(m_phase, was_rst), "farm_lamp", farm_lamp, exp_farm(m_phase));
    check(was_rst ? "R1" : "R8", "timer_start", timer_start, m_st);
    check("R2", "lamp onehot", ($countones(hwy_lamp) == 1) && ($countones(farm_lamp) == 1), 1);
    // run lengths seen at the ports
    if (hwy_lamp == 3'b001) hg_run++;
    else begin
      if (hg_run > 0) check("R3", "hwy green run >= LONG", hg_run >= LONG, 1);
      hg_run = 0;
    end
    if (farm_lamp == 3'b001) fg_run++;
    else begin
      if (fg_run > 0) check("R6", "farm green run <= LONG", fg_run <= LONG, 1);
      fg_run = 0;
    end
    car_waiting = c;
    rst = r;
    if (r) begin
      m_phase = 0; m_cnt = 0; m_st = 0;
    end else begin
      case (m_phase)
        0: ex = c && (m_cnt >= LONG - 1);
        1: ex = (m_cnt >= SHORT - 1);
        2: ex = !c || (m_cnt >= LONG - 1);
        default: ex = (m_cnt >= SHORT - 1);
      endcase
      m_st = ex;
      if (ex) begin
        m_phase = (m_phase + 1) % 4;
        m_cnt = 0;
      end else m_cnt++;
    end
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    // R1: reset state
    for (int i = 0; i < 3; i++) step(1'b0, 1'b1);
    // R4: no car for a long stretch
    for (int i = 0; i < 40; i++) step(1'b0, 1'b0);
    // R3/R5/R6/R7: car present throughout, full cycles with capped farm green
    for (int i = 0; i < 70; i++) step(1'b1, 1'b0);
    // R6: car gone right as farm go starts -> single-cycle farm green
    for (int i = 0; i < 40; i++) step(i % 2 == 0, 1'b0);
    // car arrives only after long idle: highway leaves at once
    for (int i = 0; i < 30; i++) step(1'b0, 1'b0);
    for (int i = 0; i < 20; i++) step(1'b1, 1'b0);
    // R1: reset in the middle of a phase
    for (int i = 0; i < 13; i++) step(1'b1, 1'b0);
    step(1'b1, 1'b1);
    for (int i = 0; i < 30; i++) step(1'b1, 1'b0);
    // random traffic with rare toggles
    begin
      logic c = 1'b0;
      for (int i = 0; i < 3000; i++) begin
        if ($urandom_range(7) == 0) c = ~c;
        step(c, ($urandom_range(499) == 0));
      end
    end
    // random traffic with frequent toggles
    for (int i = 0; i < 1000; i++) step(1'($urandom_range(1)), 1'b0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule